// File: doc/BRIEF.md
# Timer Channel Control Word and Status Latch

This block sits beside the down-counter of one timer channel. It keeps the 8-bit control word that the host last wrote, decodes from it the counting mode and the decimal-counting flag, and tracks whether the most recent count written by the host has reached the counting element yet. That pending-load condition is the null-count flag.

When the host asks for status, the block captures one status byte and offers it on a valid/ready output. The byte carries the output pin level in bit 7, the null-count flag in bit 6, and the low six control bits in bits 5..0. The byte stays captured until the host takes it. The counter itself and the selection of a channel by address lie outside this block. The counter reports the moment it takes a count through `cnt_load`.

The status output follows valid/ready rules. Once `st_valid` rises, `st_byte` holds steady until a cycle in which `st_valid` and `st_ready` are both high. After that cycle `st_valid` drops. A consumer may hold `st_ready` low for as long as it likes, and nothing is lost.

Top module: `tcs_top`

## Requirements
- R1: After reset, `ctl_word` is 0, `mode` is 0, `bcd` is 0, `null_cnt` is 1 and `st_valid` is 0.
- R2: A cycle with `cw_wr` high stores `cw_data` whole. `ctl_word` shows it from the next cycle, and `bcd` equals bit 0 of it.
- R3: `mode` is bits 3..1 of the stored word for codes 0 to 5. Code 6 gives mode 2 and code 7 gives mode 3, so `mode` is never above 5.
- R4: A cycle with `cw_wr` or `cnt_wr` high makes `null_cnt` 1 on the next cycle, even when `cnt_load` is high in the same cycle.
- R5: A cycle with `cnt_load` high and neither write high makes `null_cnt` 0 on the next cycle. Without any of the three inputs, `null_cnt` keeps its value.
- R6: `latch_req` while `st_valid` is 0 makes `st_valid` 1 on the next cycle. `st_byte` is then {`out_lvl`, `null_cnt`, `ctl_word[5:0]`}, taken from the values present in the request cycle.
- R7: While `st_valid` is 1 and `st_ready` is 0, `st_byte` and `st_valid` hold. A `latch_req` in that state is ignored.
- R8: A cycle with `st_valid` and `st_ready` both high makes `st_valid` 0 on the next cycle. A new latch is accepted from that cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_wr | input | 1 | Control word write strobe |
| cw_data | input | 8 | Control word from host |
| cnt_wr | input | 1 | Host wrote a new count |
| cnt_load | input | 1 | Counter took the count into its counting element |
| out_lvl | input | 1 | Present level of the channel output pin |
| latch_req | input | 1 | Status latch command |
| st_ready | input | 1 | Host accepts the status byte |
| ctl_word | output | 8 | Stored control word |
| mode | output | 3 | Decoded counting mode 0..5 |
| bcd | output | 1 | Decimal counting selected |
| null_cnt | output | 1 | Written count not yet loaded |
| st_valid | output | 1 | Status byte pending |
| st_byte | output | 8 | Latched status byte |

## Verification
The assertions assume that `cnt_load` is driven by a counter that obeys its own timing. They do not check it against the write strobes, so any mix of `cw_wr`, `cnt_wr` and `cnt_load` in one cycle is legal input. The bench relies on this and drives all three independently at random, including cycles where they coincide.

The handshake checks assume that the consumer does not expect a byte to change while `st_ready` is low. The stimulus therefore holds `st_ready` low for long stretches while it fires extra `latch_req` pulses and toggles `out_lvl`. Directed phases cover every mode code and the set-over-clear priority.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int CW_W   = 8;
  localparam int KEEP_W = 6;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic              out_lvl;
    logic              null_cnt;
    logic [KEEP_W-1:0] ctl;
  } stat_t;
endpackage

// File: rtl/tcs_ctl_reg.sv
module tcs_ctl_reg #(
  parameter int W        = 8,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cw_wr,
  input  logic [W-1:0] cw_data,
  input  logic         cnt_wr,
  input  logic         cnt_load,
  output logic [W-1:0] ctl_q,
  output logic         null_q
);
  logic set_n, clr_n;

  assign set_n = cw_wr | cnt_wr;

  generate
    if (SET_WINS) begin : g_set_prio
      assign clr_n = cnt_load & ~set_n;
    end else begin : g_clr_prio
      assign clr_n = cnt_load;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (cw_wr) begin
      ctl_q <= cw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      null_q <= 1'b1;
    end else if (clr_n) begin
      null_q <= 1'b0;
    end else if (set_n) begin
      null_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tcs_mode_dec.sv
module tcs_mode_dec #(
  parameter int MW = 3
) (
  input  logic [MW-1:0] raw,
  output logic [MW-1:0] mode
);
  // Codes 6 and 7 fold onto 2 and 3: the top bit only counts when the low pair is 0 or 1.
  always_comb begin
    mode = raw;
    if (raw[1]) mode[MW-1] = 1'b0;
  end
endmodule

// File: rtl/tcs_stat_latch.sv
module tcs_stat_latch
  import tcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   latch_req,
  input  stat_t  snap,
  input  logic   st_ready,
  output logic   st_valid,
  output stat_t  st_q
);
  logic take, give;

  assign take = latch_req & ~st_valid;
  assign give = st_valid & st_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
    end else if (take) begin
      st_valid <= 1'b1;
    end else if (give) begin
      st_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (take) begin
      st_q <= snap;
    end
  end
endmodule

// File: rtl/tcs_top.sv
module tcs_top
  import tcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr,
  input  logic [CW_W-1:0]   cw_data,
  input  logic              cnt_wr,
  input  logic              cnt_load,
  input  logic              out_lvl,
  input  logic              latch_req,
  input  logic              st_ready,
  output logic [CW_W-1:0]   ctl_word,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic              null_cnt,
  output logic              st_valid,
  output logic [CW_W-1:0]   st_byte
);
  stat_t snap, st_q;

  tcs_ctl_reg #(.W(CW_W), .SET_WINS(1'b1)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .cw_data(cw_data),
    .cnt_wr(cnt_wr), .cnt_load(cnt_load), .ctl_q(ctl_word), .null_q(null_cnt)
  );

  tcs_mode_dec #(.MW(MODE_W)) u_dec (
    .raw(ctl_word[MODE_W:1]), .mode(mode)
  );

  assign bcd = ctl_word[0];

  always_comb begin
    snap.out_lvl  = out_lvl;
    snap.null_cnt = null_cnt;
    snap.ctl      = ctl_word[KEEP_W-1:0];
  end

  tcs_stat_latch u_st (
    .clk(clk), .rst_n(rst_n), .latch_req(latch_req), .snap(snap),
    .st_ready(st_ready), .st_valid(st_valid), .st_q(st_q)
  );

  assign st_byte = st_q;
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cw_wr,
  input logic [7:0] cw_data,
  input logic       cnt_wr,
  input logic       cnt_load,
  input logic       out_lvl,
  input logic       latch_req,
  input logic       st_ready,
  input logic [7:0] ctl_word,
  input logic [2:0] mode,
  input logic       bcd,
  input logic       null_cnt,
  input logic       st_valid,
  input logic [7:0] st_byte
);
  p_ctl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |=> (ctl_word == $past(cw_data)) && (bcd == $past(cw_data[0])));
  p_mode_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode < 3'd6);
  p_null_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr || cnt_wr) |=> null_cnt);
  p_null_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !cw_wr && !cnt_wr) |=> !null_cnt);
  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_req && !st_valid) |=> st_valid && (st_byte[7] == $past(out_lvl))
      && (st_byte[6] == $past(null_cnt)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> st_valid && $stable(st_byte));
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !st_valid);
endmodule

bind tcs_top tcs_chk u_chk (.*);

// File: tb/sim_tcs_top.sv
module sim_tcs_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cw_wr = 1'b0, cnt_wr = 1'b0, cnt_load = 1'b0;
  logic       out_lvl = 1'b0, latch_req = 1'b0, st_ready = 1'b0;
  logic [7:0] cw_data = '0;
  logic [7:0] ctl_word, st_byte;
  logic [2:0] mode;
  logic       bcd, null_cnt, st_valid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_ctl = 0, m_null = 1, m_sv = 0, m_sb = 0;

  always #5 clk = ~clk;

  tcs_top u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int alias_mode(input int code);
    if (code >= 6) return code - 4;
    return code;
  endfunction

  task automatic compare_all();
    chk("R2 ctl_word", ctl_word, m_ctl);
    chk("R2 bcd", bcd, m_ctl % 2);
    chk("R3 mode", mode, alias_mode((m_ctl / 2) % 8));
    chk("R4/R5 null_cnt", null_cnt, m_null);
    chk("R6/R8 st_valid", st_valid, m_sv);
    if (m_sv != 0) chk("R6/R7 st_byte", st_byte, m_sb);
  endtask

  task automatic step();
    int n_null;
    @(posedge clk);
    if (latch_req && m_sv == 0) begin
      m_sb = (out_lvl ? 128 : 0) + (m_null ? 64 : 0) + (m_ctl % 64);
      m_sv = 1;
    end else if (m_sv == 1 && st_ready) begin
      m_sv = 0;
    end
    n_null = m_null;
    if (cw_wr || cnt_wr) n_null = 1;
    else if (cnt_load) n_null = 0;
    m_null = n_null;
    if (cw_wr) m_ctl = cw_data;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    cw_wr = 0; cnt_wr = 0; cnt_load = 0; latch_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ctl_word", ctl_word, 0);
    chk("R1 mode", mode, 0);
    chk("R1 bcd", bcd, 0);
    chk("R1 null_cnt", null_cnt, 1);
    chk("R1 st_valid", st_valid, 0);
    rst_n = 1'b1;
    step();

    // R3 every mode code, with bcd alternating
    for (int c = 0; c < 8; c++) begin
      idle(); cw_wr = 1; cw_data = 8'(8'h30 | (c << 1) | (c & 1));
      step();
      idle(); step();
      chk("R3 directed mode", mode, alias_mode(c));
    end

    // R4 set wins over load in the same cycle
    idle(); cnt_load = 1; step();
    chk("R5 load clears", null_cnt, 0);
    idle(); cnt_wr = 1; cnt_load = 1; step();
    chk("R4 set over load", null_cnt, 1);
    idle(); cnt_load = 1; step();
    idle(); step();
    chk("R5 hold", null_cnt, 0);

    // R7 second latch ignored while pending
    idle(); out_lvl = 1; latch_req = 1; st_ready = 0; step();
    chk("R6 out bit", st_byte[7], 1);
    idle(); out_lvl = 0; cw_wr = 1; cw_data = 8'h3A; latch_req = 1; step();
    idle(); latch_req = 1; step();
    chk("R7 ignored latch", st_byte[7], 1);
    chk("R7 ignored latch ctl", st_byte[5:0], m_sb % 64);
    idle(); st_ready = 1; step();
    chk("R8 drop", st_valid, 0);
    idle(); latch_req = 1; step();
    chk("R8 relatch", st_valid, 1);
    chk("R6 new ctl bits", st_byte[5:0], 6'h3A);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cw_wr     = ($urandom % 8) == 0;
      cw_data   = 8'($urandom);
      cnt_wr    = ($urandom % 6) == 0;
      cnt_load  = ($urandom % 4) == 0;
      out_lvl   = 1'($urandom);
      latch_req = ($urandom % 3) == 0;
      st_ready  = (i % 40 < 20) ? (($urandom % 8) == 0) : 1'($urandom);
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule